// File: doc/BRIEF.md
# ADC Conversion Sequencer and Accumulator

This block is the digital side of a successive-approximation converter. It decides when a conversion starts, hands each request to the analog core through a one-cycle request and done handshake, and folds the returned 12-bit samples into a result. The trigger can be a software start command, the rising edge of an external event line, or any write to one of the two input-select registers. A small register port sets the operating mode, the sample count, the trigger source and the result format.

There are three modes. Single mode converts once per trigger and can deliver either the full 12-bit code or only its upper 8 bits. Series mode also converts once per trigger, but it sums the samples and reports only after the configured count has been collected. Burst mode takes one trigger and runs the whole count of conversions back to back. Samples are either zero-extended (single-ended) or sign-extended (differential) before summing. A result-ready flag marks each finished result and can drive an interrupt line. In single mode a free-running bit restarts the converter after every completion.

Top module: `adc_seq_accum`

## Requirements
- R1: After reset `res_rdy`, `irq` and `conv_req` are 0 and the result register (address 7) reads 0.
- R2: In single mode (CTRL address 0, bits [1:0] = 0) each trigger raises `conv_req` for exactly one conversion, and when it completes the result register holds the 12-bit sample right-adjusted and `res_rdy` is 1.
- R3: In single mode with CTRL bit 2 set, the result holds sample bits [11:4] right-adjusted.
- R4: With CTRL bit 3 set the result is left-adjusted in the 24-bit register: a 12-bit single result sits in bits [23:12], an 8-bit one in bits [23:16], an accumulated sum in bits [23:2].
- R5: In series mode (bits [1:0] = 1) each trigger starts one conversion; `res_rdy` stays 0 until the configured number of samples has completed, then the result is their sum, and the next run starts from a zero sum.
- R6: In burst mode (bits [1:0] = 2) one trigger issues the full count of conversions back to back, and the result is their sum.
- R7: The count field (address 1, bits [3:0]) holds k for 2^k samples, k = 0 to 10; a value above 10 acts as 10. A sum of 1024 full-scale samples (4,193,280) is reported without overflow.
- R8: With CTRL bit 4 set (differential), each sample is treated as signed two's complement and sign-extended into the sum and into the right-adjusted result.
- R9: The trigger source (address 2, bits [1:0]) is 0 for a start command (write of bit 0 = 1 to address 3), 1 for a rising edge on `evt_in`, 2 for a write to address 4 or 5; a trigger of an unselected source starts nothing.
- R10: A trigger that arrives while a conversion is in progress is ignored: no extra request and no change to the running count.
- R11: `res_rdy` clears when 1 is written to bit 0 of address 6 or when address 7 is read; `irq` is `res_rdy` gated by CTRL bit 6.
- R12: Address 4 holds the positive channel in bits [4:0] and address 5 the negative one; bits [6:5] of either write one shared path field, which both addresses read back and `chan_path` shows.
- R13: In single mode with CTRL bit 5 set, a new conversion is requested right after each completion until the bit is cleared; then the conversion in flight ends and no more follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (reading address 7 clears the flag) |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 7 | Register write data |
| cfg_rdata | output | 24 | Register read data, combinational from address |
| evt_in | input | 1 | External trigger event, rising edge active |
| conv_req | output | 1 | One-cycle request to the analog converter |
| conv_diff | output | 1 | Differential conversion selected |
| conv_done | input | 1 | Converter completion pulse |
| conv_sample | input | 12 | Converter sample, valid with `conv_done` |
| chan_pos | output | 5 | Positive input channel |
| chan_neg | output | 5 | Negative input channel |
| chan_path | output | 2 | Shared input path field |
| res_rdy | output | 1 | Result-ready flag |
| irq | output | 1 | Interrupt request |

## Verification
A sample counter that is off by one shows up at the ports as a series or burst result that is one sample too large or too small, with `res_rdy` rising one conversion early or late. In burst mode the request count also changes, and this is visible within one conversion period. A sum that is not cleared shows up in the very next series run as a wrong total. A missing sign extension shows up on the first negative differential sample as a positive 24-bit result. A trigger that is not blocked while busy shows up as an extra `conv_req` within one cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int AD_W   = 3;
    localparam int CH_W   = 5;
    localparam int PATH_W = 2;
    localparam int DW     = CH_W + PATH_W;
    localparam int LG_W   = 4;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_SERIES = 2'd1,
        MODE_BURST  = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        SRC_CMD = 2'd0,
        SRC_EVT = 2'd1,
        SRC_MUX = 2'd2
    } src_e;

    localparam logic [AD_W-1:0] A_CTRL  = 3'd0;
    localparam logic [AD_W-1:0] A_COUNT = 3'd1;
    localparam logic [AD_W-1:0] A_TRIG  = 3'd2;
    localparam logic [AD_W-1:0] A_CMD   = 3'd3;
    localparam logic [AD_W-1:0] A_MUXP  = 3'd4;
    localparam logic [AD_W-1:0] A_MUXN  = 3'd5;
    localparam logic [AD_W-1:0] A_FLAG  = 3'd6;
    localparam logic [AD_W-1:0] A_RES   = 3'd7;
endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  src_e src,
    input  logic evt_in,
    input  logic cmd_start,
    input  logic mux_wr,
    output logic trig
);
    logic evt_d, evt_q;

    always_comb begin
        evt_d = evt_in;
        case (src)
            SRC_CMD: trig = cmd_start;
            SRC_EVT: trig = evt_in & ~evt_q;
            SRC_MUX: trig = mux_wr;
            default: trig = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= evt_d;
    end
endmodule

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt #(
    parameter int SMP_W    = 12,
    parameter int ACC_W    = 22,
    parameter int NARROW_W = 8,
    parameter int RES_W    = 24
) (
    input  logic [ACC_W-1:0] raw,
    input  logic             is_acc,
    input  logic             narrow,
    input  logic             left,
    input  logic             sgn,
    output logic [RES_W-1:0] res
);
    localparam int PAD_A = RES_W - ACC_W;
    localparam int PAD_S = RES_W - SMP_W;
    localparam int PAD_N = RES_W - NARROW_W;

    logic [SMP_W-1:0]    s;
    logic [NARROW_W-1:0] nv;

    assign s  = raw[SMP_W-1:0];
    assign nv = s[SMP_W-1 -: NARROW_W];

    always_comb begin
        if (is_acc)
            res = left ? {raw, {PAD_A{1'b0}}} : {{PAD_A{sgn & raw[ACC_W-1]}}, raw};
        else if (narrow)
            res = left ? {nv, {PAD_N{1'b0}}} : {{PAD_N{sgn & nv[NARROW_W-1]}}, nv};
        else
            res = left ? {s, {PAD_S{1'b0}}} : {{PAD_S{sgn & s[SMP_W-1]}}, s};
    end
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
    import adc_seq_pkg::*;
#(
    parameter int SMP_W    = 12,
    parameter int LOG2_MAX = 10,
    parameter int NARROW_W = 8,
    parameter int RES_W    = SMP_W + LOG2_MAX + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  mode_e            mode,
    input  logic [LG_W-1:0]  log2n,
    input  logic             diff,
    input  logic             narrow,
    input  logic             left,
    input  logic             frun,
    input  logic             flag_clr,
    input  logic             conv_done,
    input  logic [SMP_W-1:0] conv_sample,
    output logic             conv_req,
    output logic             flag,
    output logic [RES_W-1:0] result
);
    localparam int ACC_W = SMP_W + LOG2_MAX;
    localparam int CNT_W = LOG2_MAX + 1;

    typedef struct packed {
        logic             busy;
        logic             req;
        logic             flag;
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
        logic [RES_W-1:0] res;
    } st_t;

    st_t st_d, st_q;

    logic [LG_W-1:0]  log2c;
    logic [CNT_W-1:0] n_m1;
    logic [ACC_W-1:0] smp_x, sum, fmt_raw;
    logic [RES_W-1:0] fmt_res;
    logic             is_single, last;

    assign log2c     = (log2n > LG_W'(LOG2_MAX)) ? LG_W'(LOG2_MAX) : log2n;
    assign n_m1      = (CNT_W'(1) << log2c) - CNT_W'(1);
    assign smp_x     = diff ? {{LOG2_MAX{conv_sample[SMP_W-1]}}, conv_sample}
                            : {{LOG2_MAX{1'b0}}, conv_sample};
    assign sum       = st_q.acc + smp_x;
    assign is_single = (mode != MODE_SERIES) && (mode != MODE_BURST);
    assign last      = is_single || (st_q.cnt == n_m1);
    assign fmt_raw   = is_single ? smp_x : sum;

    adc_seq_fmt #(
        .SMP_W(SMP_W), .ACC_W(ACC_W), .NARROW_W(NARROW_W), .RES_W(RES_W)
    ) u_fmt (
        .raw(fmt_raw), .is_acc(!is_single), .narrow(narrow & is_single),
        .left(left), .sgn(diff), .res(fmt_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (flag_clr) st_d.flag = 1'b0;
        if (!st_q.busy) begin
            if (trig) begin
                st_d.busy = 1'b1;
                st_d.req  = 1'b1;
            end
        end else if (conv_done) begin
            if (last) begin
                st_d.flag = 1'b1;
                st_d.res  = fmt_res;
                st_d.acc  = '0;
                st_d.cnt  = '0;
                if (is_single && frun) st_d.req  = 1'b1;
                else                   st_d.busy = 1'b0;
            end else begin
                st_d.acc = sum;
                st_d.cnt = st_q.cnt + CNT_W'(1);
                if (mode == MODE_BURST) st_d.req  = 1'b1;
                else                    st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign conv_req = st_q.req;
    assign flag     = st_q.flag;
    assign result   = st_q.res;

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !conv_done) |=> ($stable(st_q.acc) && $stable(st_q.cnt)));

    // R5
    flag_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && conv_done && last) |=> flag);

    // R2
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> st_q.busy);

    // R6
    burst_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && conv_done && !last && mode == MODE_BURST) |=> conv_req);
endmodule

// File: rtl/adc_seq_accum.sv
module adc_seq_accum
    import adc_seq_pkg::*;
#(
    parameter  int SMP_W    = 12,
    parameter  int LOG2_MAX = 10,
    parameter  int NARROW_W = 8,
    localparam int RES_W    = SMP_W + LOG2_MAX + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [AD_W-1:0]   cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [RES_W-1:0]  cfg_rdata,
    input  logic              evt_in,
    output logic              conv_req,
    output logic              conv_diff,
    input  logic              conv_done,
    input  logic [SMP_W-1:0]  conv_sample,
    output logic [CH_W-1:0]   chan_pos,
    output logic [CH_W-1:0]   chan_neg,
    output logic [PATH_W-1:0] chan_path,
    output logic              res_rdy,
    output logic              irq
);
    typedef struct packed {
        mode_e             mode;
        logic              narrow;
        logic              left;
        logic              diff;
        logic              frun;
        logic              ie;
        logic [LG_W-1:0]   log2n;
        src_e              src;
        logic [CH_W-1:0]   chp;
        logic [CH_W-1:0]   chn;
        logic [PATH_W-1:0] path;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic             trig, cmd_start, mux_wr, flag_clr;
    logic [RES_W-1:0] result;

    assign cmd_start = cfg_wr && (cfg_addr == A_CMD) && cfg_wdata[0];
    assign mux_wr    = cfg_wr && ((cfg_addr == A_MUXP) || (cfg_addr == A_MUXN));
    assign flag_clr  = (cfg_wr && (cfg_addr == A_FLAG) && cfg_wdata[0]) ||
                       (cfg_rd && (cfg_addr == A_RES));

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            case (cfg_addr)
                A_CTRL: begin
                    cfg_d.mode   = mode_e'(cfg_wdata[1:0]);
                    cfg_d.narrow = cfg_wdata[2];
                    cfg_d.left   = cfg_wdata[3];
                    cfg_d.diff   = cfg_wdata[4];
                    cfg_d.frun   = cfg_wdata[5];
                    cfg_d.ie     = cfg_wdata[6];
                end
                A_COUNT: cfg_d.log2n = cfg_wdata[LG_W-1:0];
                A_TRIG:  cfg_d.src   = src_e'(cfg_wdata[1:0]);
                A_MUXP: begin
                    cfg_d.chp  = cfg_wdata[CH_W-1:0];
                    cfg_d.path = cfg_wdata[DW-1:CH_W];
                end
                A_MUXN: begin
                    cfg_d.chn  = cfg_wdata[CH_W-1:0];
                    cfg_d.path = cfg_wdata[DW-1:CH_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        case (cfg_addr)
            A_CTRL:  cfg_rdata = RES_W'({cfg_q.ie, cfg_q.frun, cfg_q.diff, cfg_q.left,
                                         cfg_q.narrow, cfg_q.mode});
            A_COUNT: cfg_rdata = RES_W'(cfg_q.log2n);
            A_TRIG:  cfg_rdata = RES_W'(cfg_q.src);
            A_MUXP:  cfg_rdata = RES_W'({cfg_q.path, cfg_q.chp});
            A_MUXN:  cfg_rdata = RES_W'({cfg_q.path, cfg_q.chn});
            A_FLAG:  cfg_rdata = RES_W'(res_rdy);
            A_RES:   cfg_rdata = result;
            default: cfg_rdata = '0;
        endcase
    end

    adc_seq_trig u_trig (
        .clk(clk), .rst_n(rst_n), .src(cfg_q.src), .evt_in(evt_in),
        .cmd_start(cmd_start), .mux_wr(mux_wr), .trig(trig)
    );

    adc_seq_core #(
        .SMP_W(SMP_W), .LOG2_MAX(LOG2_MAX), .NARROW_W(NARROW_W), .RES_W(RES_W)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .trig(trig), .mode(cfg_q.mode),
        .log2n(cfg_q.log2n), .diff(cfg_q.diff), .narrow(cfg_q.narrow),
        .left(cfg_q.left), .frun(cfg_q.frun), .flag_clr(flag_clr),
        .conv_done(conv_done), .conv_sample(conv_sample), .conv_req(conv_req),
        .flag(res_rdy), .result(result)
    );

    assign conv_diff = cfg_q.diff;
    assign chan_pos  = cfg_q.chp;
    assign chan_neg  = cfg_q.chn;
    assign chan_path = cfg_q.path;
    assign irq       = res_rdy & cfg_q.ie;

    // R12
    path_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mux_wr |=> $stable(chan_path));
endmodule

// File: tb/sim_adc_seq_accum.sv
module sim_adc_seq_accum;
    localparam logic [2:0] CTRL = 3'd0, COUNT = 3'd1, TRG = 3'd2, CMD = 3'd3,
                           MUXP = 3'd4, MUXN = 3'd5, FLAG = 3'd6, RES = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [6:0]  cfg_wdata = '0;
    logic [23:0] cfg_rdata;
    logic        evt_in = 1'b0;
    logic        conv_req, conv_diff;
    logic        conv_done = 1'b0;
    logic [11:0] conv_sample = '0;
    logic [4:0]  chan_pos, chan_neg;
    logic [1:0]  chan_path;
    logic        res_rdy, irq;

    int errors = 0, checks = 0, req_cnt = 0, lidx = 0;
    logic        use_list = 1'b0;
    logic [11:0] fix_val = '0;
    logic [11:0] list [8];
    logic [23:0] rv;

    always #10 clk = ~clk;

    adc_seq_accum u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .evt_in(evt_in), .conv_req(conv_req), .conv_diff(conv_diff),
        .conv_done(conv_done), .conv_sample(conv_sample), .chan_pos(chan_pos),
        .chan_neg(chan_neg), .chan_path(chan_path), .res_rdy(res_rdy), .irq(irq)
    );

    // converter model: done two cycles after a request is seen
    initial begin
        logic pending;
        forever begin
            @(negedge clk);
            pending = conv_req;
            while (pending) begin
                @(negedge clk);
                @(negedge clk);
                conv_sample = use_list ? list[lidx] : fix_val;
                if (use_list) lidx++;
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
                req_cnt++;
                pending = conv_req;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [6:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [23:0] d);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_addr = a;
        #1 d = cfg_rdata;
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    task automatic wait_flag(input string tag, input int limit);
        int n = 0;
        while (!res_rdy && n < limit) begin
            @(negedge clk);
            n++;
        end
        chk(tag, {31'd0, res_rdy}, 32'd1);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 res_rdy", {31'd0, res_rdy}, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 conv_req", {31'd0, conv_req}, 0);
        rd(RES, rv);
        chk("R1 result", {8'd0, rv}, 0);
    endtask

    task automatic t_single;
        int c0;
        use_list = 0; fix_val = 12'hABC;
        wr(CTRL, 7'h00); wr(TRG, 7'd0);
        c0 = req_cnt;
        wr(CMD, 7'd1);
        wait_flag("R2 flag", 50);
        rd(RES, rv);
        chk("R2 result", {8'd0, rv}, 32'h000ABC);
        settle(3);
        chk("R2 one request", req_cnt - c0, 1);
        wr(CTRL, 7'h04); wr(CMD, 7'd1);
        wait_flag("R3 flag", 50); rd(RES, rv);
        chk("R3 narrow", {8'd0, rv}, 32'h0000AB);
        wr(CTRL, 7'h08); wr(CMD, 7'd1);
        wait_flag("R4 flag", 50); rd(RES, rv);
        chk("R4 left 12", {8'd0, rv}, 32'hABC000);
        wr(CTRL, 7'h0C); wr(CMD, 7'd1);
        wait_flag("R4 flag", 50); rd(RES, rv);
        chk("R4 left 8", {8'd0, rv}, 32'hAB0000);
    endtask

    task automatic t_flag;
        fix_val = 12'h123;
        wr(CTRL, 7'h00); wr(CMD, 7'd1);
        wait_flag("R11 flag", 50);
        chk("R11 irq masked", {31'd0, irq}, 0);
        wr(FLAG, 7'd1);
        chk("R11 w1c", {31'd0, res_rdy}, 0);
        wr(CTRL, 7'h40); wr(CMD, 7'd1);
        wait_flag("R11 flag", 50);
        chk("R11 irq", {31'd0, irq}, 1);
        rd(RES, rv);
        chk("R11 read clears", {31'd0, res_rdy}, 0);
        chk("R11 irq drops", {31'd0, irq}, 0);
    endtask

    task automatic t_series;
        list[0] = 12'd1; list[1] = 12'd2; list[2] = 12'd3; list[3] = 12'd4;
        lidx = 0; use_list = 1;
        wr(CTRL, 7'h01); wr(COUNT, 7'd2);
        for (int i = 0; i < 3; i++) begin
            wr(CMD, 7'd1);
            settle(8);
            chk("R5 no early flag", {31'd0, res_rdy}, 0);
        end
        wr(CMD, 7'd1);
        wait_flag("R5 flag", 50); rd(RES, rv);
        chk("R5 sum", {8'd0, rv}, 32'd10);
        use_list = 0; fix_val = 12'd5;
        for (int i = 0; i < 4; i++) begin
            wr(CMD, 7'd1);
            settle(8);
        end
        rd(RES, rv);
        chk("R5 restart from zero", {8'd0, rv}, 32'd20);
        wr(CTRL, 7'h09); wr(CMD, 7'd1); settle(8);
        wr(CMD, 7'd1); settle(8);
        wr(CMD, 7'd1); settle(8);
        wr(CMD, 7'd1); wait_flag("R4 flag", 50); rd(RES, rv);
        chk("R4 left accum", {8'd0, rv}, 32'd80);
    endtask

    task automatic t_burst;
        int c0;
        use_list = 0; fix_val = 12'd100;
        wr(CTRL, 7'h02); wr(COUNT, 7'd3);
        c0 = req_cnt;
        wr(CMD, 7'd1);
        wait_flag("R6 flag", 200); settle(3);
        chk("R6 requests", req_cnt - c0, 8);
        rd(RES, rv);
        chk("R6 sum", {8'd0, rv}, 32'd800);
        fix_val = 12'hFFF;
        wr(COUNT, 7'd10);
        c0 = req_cnt;
        wr(CMD, 7'd1);
        wait_flag("R7 flag", 10000); settle(3);
        chk("R7 count 1024", req_cnt - c0, 1024);
        rd(RES, rv);
        chk("R7 full scale sum", {8'd0, rv}, 32'd4193280);
        wr(COUNT, 7'd15);
        c0 = req_cnt;
        wr(CMD, 7'd1);
        wait_flag("R7 flag", 10000); settle(3);
        chk("R7 clamp", req_cnt - c0, 1024);
        rd(RES, rv);
    endtask

    task automatic t_diff;
        fix_val = 12'hFFF;
        wr(CTRL, 7'h10); wr(CMD, 7'd1);
        wait_flag("R8 flag", 50); rd(RES, rv);
        chk("R8 single -1", {8'd0, rv}, 32'hFFFFFF);
        fix_val = 12'h800;
        wr(CTRL, 7'h12); wr(COUNT, 7'd1); wr(CMD, 7'd1);
        wait_flag("R8 flag", 50); rd(RES, rv);
        chk("R8 burst sum", {8'd0, rv}, 32'hFFF000);
    endtask

    task automatic t_trig;
        int c0;
        fix_val = 12'h055;
        wr(CTRL, 7'h00); wr(TRG, 7'd1);
        c0 = req_cnt;
        wr(CMD, 7'd1); settle(10);
        chk("R9 cmd ignored", req_cnt - c0, 0);
        chk("R9 cmd no flag", {31'd0, res_rdy}, 0);
        @(negedge clk) evt_in = 1'b1;
        @(negedge clk) evt_in = 1'b0;
        wait_flag("R9 event", 50); rd(RES, rv);
        chk("R9 event result", {8'd0, rv}, 32'h55);
        wr(TRG, 7'd2);
        wr(MUXN, 7'h01);
        wait_flag("R9 mux write", 50); rd(RES, rv);
        wr(TRG, 7'd0);
    endtask

    task automatic t_busy;
        int c0;
        fix_val = 12'd7;
        wr(CTRL, 7'h01); wr(COUNT, 7'd1);
        c0 = req_cnt;
        wr(CMD, 7'd1); wr(CMD, 7'd1);
        settle(8);
        chk("R10 one request", req_cnt - c0, 1);
        chk("R10 no flag", {31'd0, res_rdy}, 0);
        wr(CMD, 7'd1);
        wait_flag("R10 flag", 50); rd(RES, rv);
        chk("R10 sum of two", {8'd0, rv}, 32'd14);
    endtask

    task automatic t_path;
        wr(MUXP, 7'h43);
        rd(MUXN, rv);
        chk("R12 shared readback", {8'd0, rv}, 32'h41);
        chk("R12 chan_path", {30'd0, chan_path}, 2);
        chk("R12 chan_pos", {27'd0, chan_pos}, 3);
    endtask

    task automatic t_frun;
        int c0, c1;
        fix_val = 12'd1;
        wr(CTRL, 7'h20);
        c0 = req_cnt;
        wr(CMD, 7'd1);
        settle(40);
        chk("R13 repeats", {31'd0, (req_cnt - c0) >= 5}, 1);
        wr(CTRL, 7'h00);
        settle(20);
        c1 = req_cnt;
        settle(40);
        chk("R13 stops", req_cnt, c1);
        wr(FLAG, 7'd1);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_flag();
        t_series();
        t_burst();
        t_diff();
        t_trig();
        t_busy();
        t_path();
        t_frun();
        summary();
        $finish;
    end
endmodule